// File: doc/BRIEF.md
# Period-Measuring Capture Timer

A 16-bit counter that advances on one of several count enables and can snapshot its running value whenever a slow external event occurs. The count enable is either every system clock, a tick every 12 system clocks, each rising edge of a comparator output, or one tick per 8 rising edges of a slow oscillator input. Counting happens only while the run input is high. Both slow inputs are brought into the system clock domain through a synchronizer, and their rising edges become single-cycle pulses.

With capture enabled, the capture event is either a comparator rising edge or every eighth oscillator rising edge. On each event the current count is copied into the reload register and a sticky flag is raised. The flag also drives an interrupt when the interrupt enable is high. Software finds the period of the slow source by subtracting two successive captured values. In that mode an overflow wraps the counter to zero, so the differences stay correct modulo 2^16. With capture disabled, an overflow loads the count from the reload register. Either way, an overflow also raises the flag.

Software reaches the count, the reload value and the flag through a simple byte-wide write port and a combinational read port.

Top module: `period_capture_timer`

## Requirements
- R1: After reset the count is 0, the reload value is 0, the flag is 0 and `irq_o` is 0.
- R2: While `sysclk_mode_i` is 1 and `run_i` is 1, the count rises by one on every clock, whatever `clk_sel_i` holds.
- R3: With `sysclk_mode_i` 0 and `clk_sel_i` 00 or 10, the count rises by one per 12 clocks of run time. Exactly 10 counts are gained over any 120 clocks of run.
- R4: With `clk_sel_i` 01, the count rises by one per rising edge of `cmp_i`.
- R5: With `clk_sel_i` 11, the count rises by one per 8 rising edges of `rtc_i`. The 8-edge divider restarts at reset.
- R6: While `run_i` is 0, the count does not change, whatever the selected source does.
- R7: With `capture_en_i` 1 and `cap_src_i` 1, each `cmp_i` rising edge copies the count into the reload register and sets the flag. The value captured is the count two clocks after the edge is presented at a falling clock edge.
- R8: With `capture_en_i` 1 and `cap_src_i` 0, a capture happens on every eighth `rtc_i` rising edge only. Seven further edges leave the reload value and the flag unchanged.
- R9: On overflow from 0xFFFF, the count loads the reload value if `capture_en_i` is 0 and wraps to 0 if `capture_en_i` is 1. In both cases the flag is set.
- R10: Writing a value with bit 0 = 0 to address 4 clears the flag. Writing bit 0 = 1 has no effect. A capture in the same cycle as a clear leaves the flag set.
- R11: `irq_o` is high exactly when the flag is set and `irq_en_i` is 1.
- R12: The address map is: 0 count low byte, 1 count high byte, 2 reload low byte, 3 reload high byte, 4 flag in bit 0 (other bits read 0). Writes to 0..3 load that byte, and reads return the current value combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmp_i | input | 1 | Comparator output, asynchronous |
| rtc_i | input | 1 | Slow oscillator clock, asynchronous |
| run_i | input | 1 | Counting allowed |
| sysclk_mode_i | input | 1 | Count every system clock, overriding `clk_sel_i` |
| clk_sel_i | input | 2 | Count source: X0 clock/12, 01 comparator, 11 oscillator/8 |
| capture_en_i | input | 1 | Capture mode enable |
| cap_src_i | input | 1 | Capture trigger: 1 comparator edge, 0 every 8 oscillator edges |
| irq_en_i | input | 1 | Interrupt enable |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 8 | Register write data |
| rd_addr_i | input | 3 | Register read address |
| rd_data_o | output | 8 | Register read data |
| flag_o | output | 1 | Capture/overflow flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with its defaults: a 16-bit count, a prescaler of 12, an oscillator divider of 8 and a two-stage synchronizer. Those values make the expected results exact. The synchronizer latency is fixed at two clocks, so captured values can be predicted to the cycle. A 120-clock run window holds exactly ten prescaler ticks, and sixteen oscillator edges give two capture points. Preloading the count just below 0xFFFF reaches both overflow behaviours within a few cycles, and the same-cycle capture-and-clear collision can be placed on a known edge.

// File: rtl/pct_pkg.sv
package pct_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    CSEL_PRE     = 2'b00,
    CSEL_CMP     = 2'b01,
    CSEL_PRE_ALT = 2'b10,
    CSEL_RTC     = 2'b11
  } clk_sel_e;
endpackage

// File: rtl/edge_sync.sv
module edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o
);
  logic [STAGES-1:0] sr_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      sr_q   <= {sr_q[STAGES-2:0], d_i};
      prev_q <= sr_q[STAGES-1];
    end
  end

  assign rise_o = sr_q[STAGES-1] & ~prev_q;

  p_single_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/tick_gen.sv
module tick_gen #(
  parameter int unsigned PRE_DIV = 12,
  parameter int unsigned RTC_DIV = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rtc_rise_i,
  output logic pre_tick_o,
  output logic rtc_tick_o
);
  localparam int unsigned PRE_W = $clog2(PRE_DIV);
  localparam int unsigned RTC_W = $clog2(RTC_DIV);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRE_DIV - 1);
  localparam logic [RTC_W-1:0] RTC_LAST = RTC_W'(RTC_DIV - 1);

  logic [PRE_W-1:0] pre_q;
  logic [RTC_W-1:0] rtc_q;

  // free-running prescaler
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              pre_q <= '0;
    else if (pre_q == PRE_LAST) pre_q <= '0;
    else                      pre_q <= pre_q + 1'b1;
  end

  // counts synchronized oscillator edges
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rtc_q <= '0;
    else if (rtc_rise_i) begin
      if (rtc_q == RTC_LAST) rtc_q <= '0;
      else                   rtc_q <= rtc_q + 1'b1;
    end
  end

  assign pre_tick_o = (pre_q == PRE_LAST);
  assign rtc_tick_o = rtc_rise_i && (rtc_q == RTC_LAST);

  p_pre_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_tick_o |=> !pre_tick_o);
  p_rtc_tick_edge_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rtc_tick_o |=> (rtc_q == '0));
endmodule

// File: rtl/count_core.sv
module count_core #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              count_en_i,
  input  logic              cap_evt_i,
  input  logic              cap_mode_i,
  input  logic              irq_en_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  output logic [CNT_W-1:0]  count_o,
  output logic [CNT_W-1:0]  reload_o,
  output logic              flag_o,
  output logic              irq_o
);
  localparam int unsigned BYTES = CNT_W / 8;
  localparam logic [ADDR_W-1:0] FLAG_ADDR = ADDR_W'(2 * BYTES);
  localparam logic [CNT_W-1:0]  CNT_MAX   = '1;

  logic [CNT_W-1:0] count_q, count_d, reload_q, reload_d;
  logic             flag_q;
  logic [BYTES-1:0] cnt_wr, rld_wr;
  logic             overflow, flag_clr;

  for (genvar b = 0; b < BYTES; b++) begin : g_lane
    assign cnt_wr[b] = wr_en_i && (wr_addr_i == ADDR_W'(b));
    assign rld_wr[b] = wr_en_i && (wr_addr_i == ADDR_W'(BYTES + b));
  end

  assign overflow = count_en_i && (count_q == CNT_MAX);
  assign flag_clr = wr_en_i && (wr_addr_i == FLAG_ADDR) && !wr_data_i[0];

  always_comb begin
    count_d = count_q;
    if (count_en_i) begin
      if (count_q == CNT_MAX) count_d = cap_mode_i ? '0 : reload_q;
      else                    count_d = count_q + 1'b1;
    end
    for (int b = 0; b < BYTES; b++)
      if (cnt_wr[b]) count_d[8*b +: 8] = wr_data_i;
  end

  // capture has priority over a software reload write
  always_comb begin
    reload_d = reload_q;
    for (int b = 0; b < BYTES; b++)
      if (rld_wr[b]) reload_d[8*b +: 8] = wr_data_i;
    if (cap_evt_i) reload_d = count_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q  <= '0;
      reload_q <= '0;
      flag_q   <= 1'b0;
    end else begin
      count_q  <= count_d;
      reload_q <= reload_d;
      flag_q   <= (flag_q & ~flag_clr) | cap_evt_i | overflow;
    end
  end

  assign count_o  = count_q;
  assign reload_o = reload_q;
  assign flag_o   = flag_q;
  assign irq_o    = flag_q & irq_en_i;

  p_capture_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_evt_i |=> (reload_q == $past(count_q)));
  p_flag_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !flag_clr) |=> flag_q);
  p_set_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_evt_i && flag_clr) |=> flag_q);
  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!count_en_i && !(|cnt_wr)) |=> $stable(count_q));
  p_wrap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overflow && cap_mode_i && !(|cnt_wr)) |=> (count_q == '0 && flag_q));
  p_reload_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overflow && !cap_mode_i && !(|cnt_wr) && !(|rld_wr) && !cap_evt_i)
      |=> (count_q == reload_q && flag_q));
endmodule

// File: rtl/period_capture_timer.sv
module period_capture_timer #(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned PRE_DIV     = 12,
  parameter int unsigned RTC_DIV     = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned ADDR_W      = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmp_i,
  input  logic              rtc_i,
  input  logic              run_i,
  input  logic              sysclk_mode_i,
  input  logic [1:0]        clk_sel_i,
  input  logic              capture_en_i,
  input  logic              cap_src_i,
  input  logic              irq_en_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o,
  output logic              flag_o,
  output logic              irq_o
);
  import pct_pkg::*;

  localparam int unsigned BYTES  = CNT_W / BYTE_W;
  localparam int unsigned N_SLOW = 2;
  localparam logic [ADDR_W-1:0] FLAG_ADDR = ADDR_W'(2 * BYTES);

  logic [N_SLOW-1:0] slow_raw, slow_rise;
  logic              cmp_rise, rtc_rise, pre_tick, rtc_tick;
  logic              src_tick, count_en, cap_evt;
  logic [CNT_W-1:0]  count, reload;
  logic              flag;

  assign slow_raw = {rtc_i, cmp_i};

  for (genvar g = 0; g < N_SLOW; g++) begin : g_sync
    edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (slow_raw[g]),
      .rise_o (slow_rise[g])
    );
  end

  assign cmp_rise = slow_rise[0];
  assign rtc_rise = slow_rise[1];

  tick_gen #(.PRE_DIV(PRE_DIV), .RTC_DIV(RTC_DIV)) u_ticks (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rtc_rise_i (rtc_rise),
    .pre_tick_o (pre_tick),
    .rtc_tick_o (rtc_tick)
  );

  always_comb begin
    unique case (clk_sel_e'(clk_sel_i))
      CSEL_CMP: src_tick = cmp_rise;
      CSEL_RTC: src_tick = rtc_tick;
      default:  src_tick = pre_tick;
    endcase
  end

  assign count_en = run_i & (sysclk_mode_i | src_tick);
  assign cap_evt  = capture_en_i & (cap_src_i ? cmp_rise : rtc_tick);

  count_core #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .count_en_i (count_en),
    .cap_evt_i  (cap_evt),
    .cap_mode_i (capture_en_i),
    .irq_en_i   (irq_en_i),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .count_o    (count),
    .reload_o   (reload),
    .flag_o     (flag),
    .irq_o      (irq_o)
  );

  always_comb begin
    rd_data_o = '0;
    for (int b = 0; b < BYTES; b++) begin
      if (rd_addr_i == ADDR_W'(b))         rd_data_o = count[8*b +: 8];
      if (rd_addr_i == ADDR_W'(BYTES + b)) rd_data_o = reload[8*b +: 8];
    end
    if (rd_addr_i == FLAG_ADDR) rd_data_o = {7'b0, flag};
  end

  assign flag_o = flag;

  p_irq_gate_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_en_i || !flag_o) |-> !irq_o);
  p_stopped_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !wr_en_i) |=> (count == $past(count)));
  p_sysclk_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && sysclk_mode_i && !wr_en_i && count != '1) |=> (count == $past(count) + 1'b1));
endmodule

// File: tb/period_capture_timer_test.sv
`timescale 1ns/1ps
module period_capture_timer_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cmp_i = 1'b0, rtc_i = 1'b0, run_i = 1'b0, sysclk_mode_i = 1'b0;
  logic [1:0] clk_sel_i = 2'b00;
  logic       capture_en_i = 1'b0, cap_src_i = 1'b0, irq_en_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [2:0] wr_addr_i = '0, rd_addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic [7:0] rd_data_o;
  logic       flag_o, irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  period_capture_timer uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .cmp_i(cmp_i), .rtc_i(rtc_i), .run_i(run_i),
    .sysclk_mode_i(sysclk_mode_i), .clk_sel_i(clk_sel_i), .capture_en_i(capture_en_i),
    .cap_src_i(cap_src_i), .irq_en_i(irq_en_i), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
    .flag_o(flag_o), .irq_o(irq_o)
  );

  always #2.5 clk_i = ~clk_i;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // all tasks begin and end just after a falling edge
  task automatic do_reset();
    rst_ni = 1'b0; run_i = 0; sysclk_mode_i = 0; clk_sel_i = 0; capture_en_i = 0;
    cap_src_i = 0; irq_en_i = 0; cmp_i = 0; rtc_i = 0; wr_en_i = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(posedge clk_i); @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd16(input logic [2:0] base, output int v);
    logic [7:0] lo;
    rd_addr_i = base; #1 lo = rd_data_o;
    rd_addr_i = base + 3'd1; #1 v = {rd_data_o, lo};
  endtask

  task automatic wr16(input logic [2:0] base, input logic [15:0] v);
    wr_reg(base, v[7:0]);
    wr_reg(base + 3'd1, v[15:8]);
  endtask

  task automatic run_cycles(input int n);
    run_i = 1'b1;
    repeat (n) @(posedge clk_i);
    @(negedge clk_i);
    run_i = 1'b0;
  endtask

  task automatic pulse_cmp(input int hi, input int lo);
    cmp_i = 1'b1; repeat (hi) @(negedge clk_i);
    cmp_i = 1'b0; repeat (lo) @(negedge clk_i);
  endtask

  task automatic pulse_rtc(input int hi, input int lo);
    rtc_i = 1'b1; repeat (hi) @(negedge clk_i);
    rtc_i = 1'b0; repeat (lo) @(negedge clk_i);
  endtask

  task automatic t_reset();
    int v;
    do_reset();
    rd16(3'd0, v); check("R1 count", v, 0);
    rd16(3'd2, v); check("R1 reload", v, 0);
    check("R1 flag", flag_o, 0);
    check("R1 irq", irq_o, 0);
  endtask

  task automatic t_regs();
    int v;
    do_reset();
    wr16(3'd0, 16'hA55A); wr16(3'd2, 16'h1234);
    rd16(3'd0, v); check("R12 count bytes", v, 16'hA55A);
    rd16(3'd2, v); check("R12 reload bytes", v, 16'h1234);
    rd_addr_i = 3'd4; #1 check("R12 flag read", rd_data_o, 0);
  endtask

  task automatic t_sysclk();
    int v;
    do_reset();
    sysclk_mode_i = 1; clk_sel_i = 2'b01;
    run_cycles(50);
    rd16(3'd0, v); check("R2 sysclk count", v, 50);
  endtask

  task automatic t_prescale();
    int v;
    do_reset();
    clk_sel_i = 2'b00;
    repeat (5) @(negedge clk_i);
    run_cycles(120);
    rd16(3'd0, v); check("R3 sel 00", v, 10);
    clk_sel_i = 2'b10;
    run_cycles(120);
    rd16(3'd0, v); check("R3 sel 10", v, 20);
  endtask

  task automatic t_cmp_count();
    int v;
    do_reset();
    clk_sel_i = 2'b01; run_i = 1;
    repeat (5) pulse_cmp(3, 3);
    repeat (4) @(negedge clk_i);
    run_i = 0;
    rd16(3'd0, v); check("R4 cmp edges", v, 5);
  endtask

  task automatic t_rtc_count();
    int v;
    do_reset();
    clk_sel_i = 2'b11; run_i = 1;
    repeat (16) pulse_rtc(2, 2);
    repeat (4) @(negedge clk_i);
    run_i = 0;
    rd16(3'd0, v); check("R5 rtc/8", v, 2);
  endtask

  task automatic t_stopped();
    int v;
    do_reset();
    wr16(3'd0, 16'h0077);
    sysclk_mode_i = 1;
    repeat (40) @(negedge clk_i);
    sysclk_mode_i = 0; clk_sel_i = 2'b01;
    repeat (4) pulse_cmp(2, 2);
    rd16(3'd0, v); check("R6 no run", v, 16'h0077);
  endtask

  task automatic t_cap_cmp();
    int v;
    do_reset();
    sysclk_mode_i = 1; capture_en_i = 1; cap_src_i = 1;
    run_i = 1; cmp_i = 1;
    repeat (3) @(negedge clk_i);
    cmp_i = 0; repeat (7) @(negedge clk_i);
    rd16(3'd2, v); check("R7 first capture", v, 2);
    check("R7 flag", flag_o, 1);
    pulse_cmp(3, 7);
    run_i = 0;
    rd16(3'd2, v); check("R7 second capture", v, 12);
  endtask

  task automatic t_cap_rtc();
    int v;
    do_reset();
    sysclk_mode_i = 1; capture_en_i = 1; cap_src_i = 0;
    run_i = 1;
    repeat (8) pulse_rtc(3, 3);
    rd16(3'd2, v); check("R8 capture at 8th edge", v, 44);
    check("R8 flag", flag_o, 1);
    wr_reg(3'd4, 8'h00);
    repeat (7) pulse_rtc(3, 3);
    run_i = 0;
    rd16(3'd2, v); check("R8 seven edges no capture", v, 44);
    check("R8 flag clear", flag_o, 0);
  endtask

  task automatic t_overflow();
    int v;
    do_reset();
    wr16(3'd2, 16'hFFF0); wr16(3'd0, 16'hFFFE);
    sysclk_mode_i = 1;
    run_cycles(2);
    rd16(3'd0, v); check("R9 reload on overflow", v, 16'hFFF0);
    check("R9 flag reload", flag_o, 1);
    wr_reg(3'd4, 8'h00);
    capture_en_i = 1; cap_src_i = 1;
    wr16(3'd0, 16'hFFFE);
    run_cycles(2);
    rd16(3'd0, v); check("R9 wrap in capture mode", v, 0);
    check("R9 flag wrap", flag_o, 1);
  endtask

  task automatic t_flag();
    do_reset();
    capture_en_i = 1; cap_src_i = 1;
    pulse_cmp(3, 4);
    check("R10 flag set", flag_o, 1);
    wr_reg(3'd4, 8'h01);
    check("R10 write 1 no effect", flag_o, 1);
    wr_reg(3'd4, 8'hFE);
    check("R10 clear", flag_o, 0);
    cmp_i = 1;
    @(posedge clk_i); @(posedge clk_i); @(negedge clk_i);
    wr_en_i = 1; wr_addr_i = 3'd4; wr_data_i = 8'h00;
    @(posedge clk_i); @(negedge clk_i);
    wr_en_i = 0; cmp_i = 0;
    check("R10 capture beats clear", flag_o, 1);
  endtask

  task automatic t_irq();
    do_reset();
    capture_en_i = 1; cap_src_i = 1;
    pulse_cmp(3, 4);
    #1 check("R11 masked", irq_o, 0);
    irq_en_i = 1; #1 check("R11 enabled", irq_o, 1);
    @(negedge clk_i);
    wr_reg(3'd4, 8'h00);
    #1 check("R11 cleared", irq_o, 0);
  endtask

  initial begin
    @(negedge clk_i);
    t_reset();
    t_regs();
    t_sysclk();
    t_prescale();
    t_cmp_count();
    t_rtc_count();
    t_stopped();
    t_cap_cmp();
    t_cap_rtc();
    t_overflow();
    t_flag();
    t_irq();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule